// File: doc/BRIEF.md
# Per-Core Two-Stage Tick Timer

This block is the private timer of one processor core. A prescaler counts down from a programmed tick value and emits one tick every (value + 1) clock cycles. Each tick steps a second down-counter loaded with an interrupt count. When that counter runs out, the block latches an interrupt status bit, and the bit drives the interrupt line when it is enabled. In interval mode the second counter reloads itself and the interrupt recurs with no software action. Otherwise it fires once and then rests at zero.

Software programs the block through a 32-bit register bus. Each instance owns one 256-byte page whose index is set by a parameter. A write to a count buffer, or to the control register, raises a write-status flag that software polls and then clears. A new interrupt count takes effect only when the write carries a load request in its top bit.

Top module: `local_tick_timer`

## Requirements
- R1: After a synchronous active-low reset, every readable register (offsets 0x00, 0x08, 0x20, 0x30, 0x34, 0x40) reads 0 and `irq_o` is 0.
- R2: The instance responds only to addresses whose bits above bit 7 equal 3 + INST_IDX. For the default, that page is 0x300. Writes to any other page change nothing.
- R3: The tick buffer sits at offset 0x00. A write to it also loads the tick counter. While control bit 0 is set, the block produces one tick every (buffer + 1) cycles.
- R4: A write to the interrupt count buffer at offset 0x08 with bit 31 set stores bits 30:0 and loads them into the interrupt counter. Without bit 31 the buffer and the counter are unchanged. The buffer reads back with bit 31 as 0.
- R5: Control sits at offset 0x20 and is read back as written. Bit 0 runs the tick counter, bit 1 runs the interrupt counter, and bit 2 selects interval mode. With counts B and N loaded and bits 0 and 1 set, the status sets N·(B+1) cycles after the control write edge. A count of 0 never expires.
- R6: In interval mode the status sets again every N·(B+1) cycles. In one-shot mode it sets once, and the counter then stays at 0 and never expires again.
- R7: Clearing both run bits freezes both counters. The remaining delay is completed after restart. A status bit that is already set stays set.
- R8: The status is bit 0 at offset 0x30, cleared by writing 1. If an expiry coincides with a clear, the set wins. `irq_o` is high exactly when status bit 0 and enable bit 0 (offset 0x34) are both 1.
- R9: The write-status register is at offset 0x40. A tick buffer write sets bit 0, any interrupt count buffer write sets bit 1, and a control write sets bit 3. Writing 1 to a bit clears it; bit 2 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Interrupt request, status gated by enable |

## Verification
The assertions guard the following on every cycle:
- the prescaler's decrement-and-reload step and the frozen state of both counters while stopped;
- the rule that a count of zero never moves;
- reload on expiry in interval mode;
- the status latch and its retention;
- the write-status acknowledgement and the rejection of off-page writes.

The end-to-end behaviour can be shown only by the bench's scenarios, which combine random tick and interrupt counts with directed corners. These cover the expiry delay of N·(B+1) cycles, the spacing of repeated interrupts, the silence after a one-shot, a delay split across a stop and a restart, and the masking of the interrupt line.

// File: rtl/tick_timer_pkg.sv
// Package: shared offsets, bit positions and types of the per-core tick timer.
// Assumes a 32-bit data bus and byte offsets within a 256-byte page.
package tick_timer_pkg;
    localparam int DATA_W = 32;
    localparam int ICNT_W = DATA_W - 1;

    localparam logic [7:0] OFS_TICK_BUF = 8'h00;
    localparam logic [7:0] OFS_ICNT_BUF = 8'h08;
    localparam logic [7:0] OFS_CTRL     = 8'h20;
    localparam logic [7:0] OFS_STAT     = 8'h30;
    localparam logic [7:0] OFS_EN       = 8'h34;
    localparam logic [7:0] OFS_WSTAT    = 8'h40;

    localparam int WS_BITS = 4;
    localparam int WS_TICK = 0;
    localparam int WS_ICNT = 1;
    localparam int WS_CTRL = 3;

    // Control word: bit 2 interval, bit 1 interrupt counter run, bit 0 tick run
    typedef struct packed {
        logic interval;
        logic int_run;
        logic tick_run;
    } ctrl_t;
endpackage

// File: rtl/tick_regs.sv
// Module: register page of one timer instance.
// Decodes the instance page, holds buffers, control, status, enable and
// write-status flags, and forms the interrupt line.
// Assumes single-cycle writes and a combinational read.
module tick_regs
    import tick_timer_pkg::*;
#(
    parameter int INST_IDX = 0,
    parameter int ADDR_W   = 12,
    parameter int TICK_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              expire_i,
    output logic              tick_load_o,
    output logic [TICK_W-1:0] tick_load_val_o,
    output logic [TICK_W-1:0] tick_buf_o,
    output logic              icnt_load_o,
    output logic [ICNT_W-1:0] icnt_load_val_o,
    output logic [ICNT_W-1:0] icnt_buf_o,
    output ctrl_t             ctrl_o,
    output logic              irq_o
);
    localparam int PAGE_W    = ADDR_W - 8;
    localparam int BASE_PAGE = 3 + INST_IDX;

    logic              page_hit;
    logic [7:0]        ofs;
    logic              wr_tick, wr_icnt, wr_ctrl, wr_stat, wr_en, wr_ws;
    logic              int_stat, int_en;
    logic [WS_BITS-1:0] wstat;
    logic [WS_BITS-1:0] ws_set;

    // Decode the page and the register offset of a write
    always_comb begin
        page_hit = (bus_addr[ADDR_W-1:8] == PAGE_W'(BASE_PAGE));
        ofs      = bus_addr[7:0];
        wr_tick  = bus_wr && page_hit && (ofs == OFS_TICK_BUF);
        wr_icnt  = bus_wr && page_hit && (ofs == OFS_ICNT_BUF);
        wr_ctrl  = bus_wr && page_hit && (ofs == OFS_CTRL);
        wr_stat  = bus_wr && page_hit && (ofs == OFS_STAT);
        wr_en    = bus_wr && page_hit && (ofs == OFS_EN);
        wr_ws    = bus_wr && page_hit && (ofs == OFS_WSTAT);
    end

    assign tick_load_o     = wr_tick;
    assign tick_load_val_o = bus_wdata[TICK_W-1:0];
    assign icnt_load_o     = wr_icnt && bus_wdata[DATA_W-1];
    assign icnt_load_val_o = bus_wdata[ICNT_W-1:0];

    // Buffers, control and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_buf_o <= '0;
            icnt_buf_o <= '0;
            ctrl_o     <= '0;
            int_en     <= 1'b0;
        end else begin
            if (wr_tick)     tick_buf_o <= bus_wdata[TICK_W-1:0];
            if (icnt_load_o) icnt_buf_o <= bus_wdata[ICNT_W-1:0];
            if (wr_ctrl)     ctrl_o     <= ctrl_t'(bus_wdata[2:0]);
            if (wr_en)       int_en     <= bus_wdata[0];
        end
    end

    // Interrupt status: set on expiry, write-1 clear, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n)                        int_stat <= 1'b0;
        else if (expire_i)                 int_stat <= 1'b1;
        else if (wr_stat && bus_wdata[0])  int_stat <= 1'b0;
    end

    assign irq_o = int_stat && int_en;

    always_comb begin
        ws_set          = '0;
        ws_set[WS_TICK] = wr_tick;
        ws_set[WS_ICNT] = wr_icnt;
        ws_set[WS_CTRL] = wr_ctrl;
    end

    // One write-status flag per acknowledged register; unused bits tie to 0
    for (genvar i = 0; i < WS_BITS; i++) begin : g_ws
        if (i == WS_TICK || i == WS_ICNT || i == WS_CTRL) begin : g_flag
            // Flag set by the register write, cleared by writing 1 to it
            always_ff @(posedge clk) begin
                if (!rst_n)                       wstat[i] <= 1'b0;
                else if (ws_set[i])               wstat[i] <= 1'b1;
                else if (wr_ws && bus_wdata[i])   wstat[i] <= 1'b0;
            end
        end else begin : g_zero
            assign wstat[i] = 1'b0;
        end
    end

    // Read multiplexer for the instance page
    always_comb begin
        bus_rdata = '0;
        if (page_hit) begin
            case (ofs)
                OFS_TICK_BUF: bus_rdata = DATA_W'(tick_buf_o);
                OFS_ICNT_BUF: bus_rdata = DATA_W'(icnt_buf_o);
                OFS_CTRL:     bus_rdata = DATA_W'(ctrl_o);
                OFS_STAT:     bus_rdata = DATA_W'(int_stat);
                OFS_EN:       bus_rdata = DATA_W'(int_en);
                OFS_WSTAT:    bus_rdata = DATA_W'(wstat);
                default:      bus_rdata = '0;
            endcase
        end
    end

    // R9
    ws_tick_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tick |=> wstat[WS_TICK]);
    // R9
    ws_ctrl_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> wstat[WS_CTRL]);
    // R8
    stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> int_stat);
    // R8
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_stat && !(wr_stat && bus_wdata[0])) |=> int_stat);
    // R2
    off_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !page_hit) |=> $stable(ctrl_o));
endmodule

// File: rtl/tick_prescaler.sv
// Module: first stage, the tick counter.
// Counts down while running and emits a one-cycle tick at zero, reloading
// from the buffer, so ticks come every (buffer + 1) cycles.
// Assumes a buffer write loads the counter directly.
module tick_prescaler #(
    parameter int TICK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              load,
    input  logic [TICK_W-1:0] load_val,
    input  logic [TICK_W-1:0] buf_val,
    output logic              tick_o
);
    logic [TICK_W-1:0] tcnt;

    assign tick_o = run && !load && (tcnt == '0);

    // Count down while running; reload from the buffer after zero
    always_ff @(posedge clk) begin
        if (!rst_n)            tcnt <= '0;
        else if (load)         tcnt <= load_val;
        else if (run) begin
            if (tcnt == '0)    tcnt <= buf_val;
            else               tcnt <= tcnt - TICK_W'(1);
        end
    end

    // R3
    tick_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && tcnt != '0) |=> tcnt == $past(tcnt) - TICK_W'(1));
    // R3
    tick_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && tcnt == '0) |=> tcnt == $past(buf_val));
    // R7
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(tcnt));
endmodule

// File: rtl/int_counter.sv
// Module: second stage, the interrupt counter.
// Steps down once per tick and expires on the step from 1 to 0. In interval
// mode the expiry reloads from the buffer; otherwise it rests at zero.
// Assumes zero means idle: a zero count never steps or expires.
module int_counter
    import tick_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              interval,
    input  logic              tick,
    input  logic              load,
    input  logic [ICNT_W-1:0] load_val,
    input  logic [ICNT_W-1:0] buf_val,
    output logic              expire_o
);
    logic [ICNT_W-1:0] icnt;
    logic              step;

    assign step     = run && tick && !load && (icnt != '0);
    assign expire_o = step && (icnt == ICNT_W'(1));

    // Load on request, step per tick, reload on expiry in interval mode
    always_ff @(posedge clk) begin
        if (!rst_n)                     icnt <= '0;
        else if (load)                  icnt <= load_val;
        else if (step) begin
            if (expire_o && interval)   icnt <= buf_val;
            else                        icnt <= icnt - ICNT_W'(1);
        end
    end

    // R6
    zero_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && icnt == '0) |=> icnt == '0);
    // R6
    interval_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && interval) |=> icnt == $past(buf_val));
    // R7
    icnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(icnt));
endmodule

// File: rtl/local_tick_timer.sv
// Module: top of one per-core tick timer instance.
// Wires the register page to the prescaler and the interrupt counter.
// Assumes one clock domain for bus and counting.
module local_tick_timer
    import tick_timer_pkg::*;
#(
    parameter int INST_IDX = 0,
    parameter int ADDR_W   = 12,
    parameter int TICK_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    logic              tick_load, icnt_load, tick, expire;
    logic [TICK_W-1:0] tick_load_val, tick_buf;
    logic [ICNT_W-1:0] icnt_load_val, icnt_buf;
    ctrl_t             ctrl;

    tick_regs #(
        .INST_IDX(INST_IDX), .ADDR_W(ADDR_W), .TICK_W(TICK_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .expire_i(expire),
        .tick_load_o(tick_load), .tick_load_val_o(tick_load_val),
        .tick_buf_o(tick_buf), .icnt_load_o(icnt_load),
        .icnt_load_val_o(icnt_load_val), .icnt_buf_o(icnt_buf),
        .ctrl_o(ctrl), .irq_o(irq_o)
    );

    tick_prescaler #(.TICK_W(TICK_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(ctrl.tick_run), .load(tick_load),
        .load_val(tick_load_val), .buf_val(tick_buf), .tick_o(tick)
    );

    int_counter u_icnt (
        .clk(clk), .rst_n(rst_n), .run(ctrl.int_run), .interval(ctrl.interval),
        .tick(tick), .load(icnt_load), .load_val(icnt_load_val),
        .buf_val(icnt_buf), .expire_o(expire)
    );
endmodule

// File: tb/local_tick_timer_test.sv
module local_tick_timer_test;
    localparam logic [11:0] BASE = 12'h300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    local_tick_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog actual %0d expected <150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int exp_delay(input int b, input int n);
        return n * (b + 1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the write edge
    task automatic wr_abs(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [7:0] ofs, input logic [31:0] d);
        wr_abs(BASE | 12'(ofs), d);
    endtask

    task automatic rd(input logic [7:0] ofs, output logic [31:0] d);
        bus_addr = BASE | 12'(ofs);
        #1 d = bus_rdata;
    endtask

    // Count edges until irq_o is seen high, bounded
    task automatic wait_irq(output int edges);
        edges = 0;
        while (edges < 3000) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (irq_o) break;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic arm(input int b, input int n);
        wr(8'h20, 0);
        wr(8'h00, 32'(b));
        wr(8'h08, 32'h8000_0000 | 32'(n));
        wr(8'h30, 1);
        wr(8'h34, 1);
    endtask

    task automatic run_case(input int b, input int n, input bit interval);
        int e;
        arm(b, n);
        wr(8'h20, interval ? 32'd7 : 32'd3);
        wait_irq(e);
        chk("R5 first expiry delay", 32'(e), 32'(exp_delay(b, n)));
        if (interval) begin
            wr(8'h30, 1);
            begin
                int e2;
                wait_irq(e2);
                chk("R6 interval spacing", 32'(e2 + 1), 32'(exp_delay(b, n)));
            end
        end else begin
            wr(8'h30, 1);
            idle(3 * exp_delay(b, n) + 4);
            chk("R6 one-shot stays silent", 32'(irq_o), 0);
        end
        wr(8'h20, 0);
    endtask

    initial begin
        logic [31:0] d;
        int e;
        int seed_init;
        seed_init = $urandom(32'd4242);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, d); chk("R1 tick buf", d, 0);
        rd(8'h08, d); chk("R1 icnt buf", d, 0);
        rd(8'h20, d); chk("R1 ctrl", d, 0);
        rd(8'h30, d); chk("R1 status", d, 0);
        rd(8'h34, d); chk("R1 enable", d, 0);
        rd(8'h40, d); chk("R1 wstat", d, 0);
        chk("R1 irq", 32'(irq_o), 0);

        // R2 writes to another instance page are ignored
        wr_abs(12'h420, 32'd3);
        rd(8'h20, d); chk("R2 off-page ctrl", d, 0);
        rd(8'h40, d); chk("R2 off-page wstat", d, 0);

        // R5 control read back
        wr(8'h20, 32'd4);
        rd(8'h20, d); chk("R5 ctrl readback", d, 4);
        wr(8'h20, 0);

        // R9 write-status flags and clearing
        wr(8'h40, 32'hF);
        wr(8'h00, 32'd2);
        rd(8'h40, d); chk("R9 tick ack", d, 32'h1);
        wr(8'h08, 32'd5);
        rd(8'h40, d); chk("R9 icnt ack without load", d, 32'h3);
        wr(8'h20, 0);
        rd(8'h40, d); chk("R9 ctrl ack", d, 32'hB);
        wr(8'h40, 32'h1);
        rd(8'h40, d); chk("R9 w1c single", d, 32'hA);
        wr(8'h40, 32'hF);
        rd(8'h40, d); chk("R9 w1c all", d, 0);

        // R4 load request bit
        rd(8'h00, d); chk("R3 tick buf readback", d, 2);
        rd(8'h08, d); chk("R4 no-load write ignored", d, 0);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, d); chk("R4 load max count", d, 32'h7FFF_FFFF);
        wr(8'h08, 32'h0000_0009);
        rd(8'h08, d); chk("R4 no-load keeps buffer", d, 32'h7FFF_FFFF);

        // R4 zero count never expires
        arm(0, 0);
        wr(8'h20, 3);
        idle(40);
        chk("R5 zero count silent", 32'(irq_o), 0);
        wr(8'h20, 0);

        // R3 tick period: N=1 gives expiry after B+1 cycles
        run_case(4, 1, 1'b0);
        run_case(0, 1, 1'b0);
        run_case(0, 3, 1'b1);
        run_case(2, 4, 1'b1);

        // R8 masking and set-wins
        arm(1, 2);
        wr(8'h34, 0);
        wr(8'h20, 3);
        idle(10);
        chk("R8 masked irq", 32'(irq_o), 0);
        rd(8'h30, d); chk("R8 status while masked", d, 1);
        wr(8'h34, 1);
        chk("R8 irq after enable", 32'(irq_o), 1);
        wr(8'h30, 1);
        chk("R8 irq after clear", 32'(irq_o), 0);
        wr(8'h20, 0);

        // R8 set wins over a clear in the same cycle: B=0, N=1, interval
        arm(0, 1);
        wr(8'h20, 7);
        idle(2);
        wr(8'h30, 1);
        rd(8'h30, d); chk("R8 set beats clear", d, 1);
        wr(8'h20, 0);

        // R7 freeze mid-count, then resume
        arm(3, 5);
        wr(8'h20, 3);
        idle(6);
        wr(8'h20, 0);
        idle(50);
        chk("R7 frozen no irq", 32'(irq_o), 0);
        wr(8'h20, 3);
        wait_irq(e);
        chk("R7 resumed remainder", 32'(e + 7), 32'(exp_delay(3, 5)));
        wr(8'h20, 0);
        idle(20);
        rd(8'h30, d); chk("R7 status kept after stop", d, 1);

        // Random cases against the computed delay
        for (int k = 0; k < 8; k++) begin
            int b, n;
            bit m;
            b = 1 + int'($urandom % 4);
            n = 1 + int'($urandom % 5);
            m = 1'($urandom % 2);
            run_case(b, n, m);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule